// File: doc/BRIEF.md
# Register-Pair Bit-Extract Execution Unit

This unit decodes and executes one instruction of a 64-bit processor datapath: it joins two source operand values into a double-width word and extracts a register-width window from it at an immediate bit position. The unit receives the 32-bit instruction word and the two operand values, which have already been read from the register file. It checks the fixed opcode pattern and the rules that make the encoding legal. It selects the 32-bit or 64-bit form from the size bit. It then returns the destination register index and the extracted value.

The unit also returns one of three outcomes for each instruction: executed, undefined encoding, or not this instruction. When the two source register indices are equal, the operation is a rotate right by an immediate, and the unit raises a hint for that case. Every input strobe produces exactly one response one clock later, whatever the operand values or the shift amount are. The execution time therefore never reveals data.

Top module: `pair_extract_unit`

## Requirements
- R1: Bits 30..23 of the instruction must equal 8'b00100111 and bit 21 must be 0. If either condition fails, the response has out_nomatch=1, out_valid=0 and out_undef=0.
- R2: A matching instruction whose bit 22 differs from bit 31 gives out_undef=1 and out_valid=0.
- R3: A matching instruction with bit 31 = 0 and bit 15 = 1 (shift amount 32 or more in the narrow form) gives out_undef=1 and out_valid=0.
- R4: If bit 31 = 1 and bit 22 = 1, out_result is the low 64 bits of {opa, opb} shifted right by insn[15:10].
- R5: If bits 31 and 22 are both 0 and bit 15 is 0, out_result is the low 32 bits of {opa[31:0], opb[31:0]} shifted right by insn[14:10], zero-extended to 64 bits.
- R6: On an executed instruction, out_dest equals insn[4:0]. The first source index is insn[9:5] and the second source index is insn[20:16].
- R7: out_ror_hint is 1 exactly when the instruction executes and insn[9:5] equals insn[20:16].
- R8: Each clock with in_valid=1 produces one response (out_ack=1) on the next clock, for any operand values and any shift amount. A clock with in_valid=0 gives out_ack=0, and out_result and out_dest keep their values.
- R9: A synchronous reset (rst=1) clears out_ack, out_valid, out_undef, out_nomatch, out_ror_hint, out_dest and out_result on the next edge, and it overrides a strobe given in the same cycle.
- R10: Each response carries exactly one of out_valid, out_undef or out_nomatch. When out_valid is 0, out_result and out_dest are 0 and out_ror_hint is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: the instruction and operands are sampled this cycle |
| insn | input | 32 | Instruction word |
| opa | input | 64 | Value of the first source register (high half of the pair) |
| opb | input | 64 | Value of the second source register (low half of the pair) |
| out_ack | output | 1 | Response present, one cycle after a strobe |
| out_valid | output | 1 | Instruction executed; out_result and out_dest are usable |
| out_undef | output | 1 | Opcode matched but the encoding is undefined |
| out_nomatch | output | 1 | Word is not this instruction |
| out_ror_hint | output | 1 | Executed with equal source indices (rotate form) |
| out_dest | output | 5 | Destination register index |
| out_result | output | 64 | Extracted value |

## Verification
Every fault in the unit surfaces on the response that follows the strobe, one clock later, because nothing is held across instructions except the last result. A wrong select in one shifter stage corrupts out_result for those shift amounts whose matching bit is set. A stuck decode term flips the outcome flags or the rotate hint for a whole class of encodings. Those encodings are the size mismatch, the oversize narrow shift, a broken opcode pattern and a set bit 21. The vectors therefore cover each shift bit, both widths, each illegal class and each outcome, and the directed tests look at held outputs during idle cycles and at reset taking priority over a strobe.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

   localparam int INSN_W    = 32;
   localparam int REG_IDX_W = 5;
   localparam int SHAMT_W   = 6;

   // Bit positions that the decoder depends on
   localparam int SIZE_BIT  = 31;
   localparam int PAT_HI    = 30;
   localparam int PAT_LO    = 23;
   localparam int SIZE2_BIT = 22;
   localparam int RSV_BIT   = 21;
   localparam int SRC2_LO   = 16;
   localparam int AMT_LO    = 10;
   localparam int SRC1_LO   = 5;
   localparam int DEST_LO   = 0;

   localparam logic [PAT_HI-PAT_LO:0] OPC_PAT = 8'b0010_0111;

   typedef struct packed {
      logic                 exec;
      logic                 undef;
      logic                 nomatch;
      logic                 wide;
      logic                 same_src;
      logic [REG_IDX_W-1:0] dest;
      logic [SHAMT_W-1:0]   amt;
   } pxu_dec_t;

endpackage

// File: rtl/pxu_decoder.sv
module pxu_decoder
   import pxu_pkg::*;
(
   input  logic [INSN_W-1:0] insn,
   output pxu_dec_t          dec
);

   logic                 opc_hit;
   logic                 size_clash;
   logic                 narrow_over;
   logic                 bad_enc;
   logic [REG_IDX_W-1:0] src1_idx;
   logic [REG_IDX_W-1:0] src2_idx;

   assign src1_idx = insn[SRC1_LO +: REG_IDX_W];
   assign src2_idx = insn[SRC2_LO +: REG_IDX_W];

   always_comb begin
      opc_hit     = (insn[PAT_HI:PAT_LO] == OPC_PAT) && !insn[RSV_BIT];
      size_clash  = insn[SIZE_BIT] ^ insn[SIZE2_BIT];
      narrow_over = !insn[SIZE_BIT] && insn[AMT_LO + SHAMT_W - 1];
      bad_enc     = size_clash || narrow_over;

      dec.nomatch  = !opc_hit;
      dec.undef    = opc_hit && bad_enc;
      dec.exec     = opc_hit && !bad_enc;
      dec.wide     = insn[SIZE_BIT];
      dec.same_src = (src1_idx == src2_idx);
      dec.dest     = insn[DEST_LO +: REG_IDX_W];
      dec.amt      = insn[AMT_LO +: SHAMT_W];
   end

endmodule

// File: rtl/pxu_funnel.sv
module pxu_funnel #(
   parameter int DATA_W      = 64,
   parameter int SHAMT_W     = 6,
   parameter int SHIFT_STYLE = 0
) (
   input  logic               wide,
   input  logic [SHAMT_W-1:0] amt,
   input  logic [DATA_W-2:0]  hi_src,
   input  logic [DATA_W-1:0]  lo_src,
   output logic [DATA_W-1:0]  result
);

   localparam int HALF_W = DATA_W / 2;
   localparam int CAT_W  = DATA_W + (1 << SHAMT_W) - 1;
   localparam int PAD_W  = CAT_W - DATA_W;

   logic [CAT_W-1:0]  cat;
   logic [DATA_W-1:0] sh;

   always_comb begin
      if (wide) cat = {hi_src, lo_src};
      else      cat = {{PAD_W{1'b0}}, hi_src[HALF_W-1:0], lo_src[HALF_W-1:0]};
   end

   generate
      if (SHIFT_STYLE == 0) begin : g_log
         // Stages go from the largest shift to the smallest, and each stage
         // keeps only the bits that can still reach the output window.
         for (genvar i = 0; i < SHAMT_W; i++) begin : g_stg
            localparam int K     = SHAMT_W - 1 - i;
            localparam int IN_W  = DATA_W + (1 << (K + 1)) - 1;
            localparam int OUT_W = DATA_W + (1 << K) - 1;
            logic [IN_W-1:0]  vin;
            logic [OUT_W-1:0] vout;
            if (i == 0) begin : g_first
               assign vin = cat;
            end else begin : g_next
               assign vin = g_stg[i-1].vout;
            end
            assign vout = amt[K] ? vin[IN_W-1:(1 << K)] : vin[OUT_W-1:0];
         end
         assign sh = g_stg[SHAMT_W-1].vout;
      end else begin : g_flat
         assign sh = DATA_W'(cat >> amt);
      end
   endgenerate

   assign result = wide ? sh : {{HALF_W{1'b0}}, sh[HALF_W-1:0]};

endmodule

// File: rtl/pxu_resp_reg.sv
module pxu_resp_reg
   import pxu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 strobe,
   input  pxu_dec_t             dec,
   input  logic [DATA_W-1:0]    value,
   output logic                 ack_q,
   output logic                 valid_q,
   output logic                 undef_q,
   output logic                 nomatch_q,
   output logic                 hint_q,
   output logic [REG_IDX_W-1:0] dest_q,
   output logic [DATA_W-1:0]    result_q
);

   logic unused_dec;
   assign unused_dec = ^{dec.wide, dec.amt};

   always_ff @(posedge clk) begin
      if (rst) begin
         ack_q     <= 1'b0;
         valid_q   <= 1'b0;
         undef_q   <= 1'b0;
         nomatch_q <= 1'b0;
         hint_q    <= 1'b0;
         dest_q    <= '0;
         result_q  <= '0;
      end else if (strobe) begin
         ack_q     <= 1'b1;
         valid_q   <= dec.exec;
         undef_q   <= dec.undef;
         nomatch_q <= dec.nomatch;
         hint_q    <= dec.exec && dec.same_src;
         dest_q    <= dec.exec ? dec.dest : '0;
         result_q  <= dec.exec ? value : '0;
      end else begin
         ack_q     <= 1'b0;
         valid_q   <= 1'b0;
         undef_q   <= 1'b0;
         nomatch_q <= 1'b0;
         hint_q    <= 1'b0;
      end
   end

endmodule

// File: rtl/pair_extract_unit.sv
module pair_extract_unit
   import pxu_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int SHIFT_STYLE = 0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [INSN_W-1:0]    insn,
   input  logic [DATA_W-1:0]    opa,
   input  logic [DATA_W-1:0]    opb,
   output logic                 out_ack,
   output logic                 out_valid,
   output logic                 out_undef,
   output logic                 out_nomatch,
   output logic                 out_ror_hint,
   output logic [REG_IDX_W-1:0] out_dest,
   output logic [DATA_W-1:0]    out_result
);

   generate
      if (DATA_W != (1 << SHAMT_W)) begin : g_bad_width
         $error("DATA_W must equal 2**SHAMT_W");
      end
      if (SHIFT_STYLE != 0 && SHIFT_STYLE != 1) begin : g_bad_style
         $error("SHIFT_STYLE must be 0 or 1");
      end
   endgenerate

   pxu_dec_t          dec;
   logic [DATA_W-1:0] ext_val;

   pxu_decoder u_dec (
      .insn (insn),
      .dec  (dec)
   );

   // The top bit of the high operand never reaches the window: the largest
   // shift leaves exactly the bits below it.
   pxu_funnel #(
      .DATA_W      (DATA_W),
      .SHAMT_W     (SHAMT_W),
      .SHIFT_STYLE (SHIFT_STYLE)
   ) u_fun (
      .wide   (dec.wide),
      .amt    (dec.amt),
      .hi_src (opa[DATA_W-2:0]),
      .lo_src (opb),
      .result (ext_val)
   );

   pxu_resp_reg #(
      .DATA_W (DATA_W)
   ) u_rsp (
      .clk       (clk),
      .rst       (rst),
      .strobe    (in_valid),
      .dec       (dec),
      .value     (ext_val),
      .ack_q     (out_ack),
      .valid_q   (out_valid),
      .undef_q   (out_undef),
      .nomatch_q (out_nomatch),
      .hint_q    (out_ror_hint),
      .dest_q    (out_dest),
      .result_q  (out_result)
   );

endmodule

// File: rtl/pxu_checker.sv
module pxu_checker
   import pxu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 in_valid,
   input logic [INSN_W-1:0]    insn,
   input logic [DATA_W-1:0]    opa,
   input logic [DATA_W-1:0]    opb,
   input logic                 out_ack,
   input logic                 out_valid,
   input logic                 out_undef,
   input logic                 out_nomatch,
   input logic                 out_ror_hint,
   input logic [REG_IDX_W-1:0] out_dest,
   input logic [DATA_W-1:0]    out_result
);

   localparam int HALF_W = DATA_W / 2;

   logic pat_ok;
   logic legal;
   assign pat_ok = (insn[30:23] == 8'b0010_0111) && !insn[21];
   assign legal  = pat_ok && (insn[31] == insn[22]) && !(!insn[31] && insn[15]);

   assert_inputs_known_R8: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> !$isunknown({insn, opa, opb}));

   assert_ack_follows_R8: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_ack);

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_ack && !out_valid && $stable(out_result) && $stable(out_dest)));

   assert_reset_clears_R9: assert property (@(posedge clk)
      rst |=> (!out_ack && !out_valid && !out_undef && !out_nomatch && out_result == '0));

   assert_nomatch_R1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !pat_ok) |=> (out_nomatch && !out_valid && !out_undef));

   assert_undef_size_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && pat_ok && (insn[31] != insn[22])) |=> (out_undef && !out_valid));

   assert_undef_shift_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && pat_ok && !insn[31] && insn[15]) |=> (out_undef && !out_valid));

   assert_wide_zero_shift_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && legal && insn[31] && insn[15:10] == 6'd0) |=> (out_result == $past(opb)));

   assert_narrow_zext_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && legal && !insn[31]) |=> (out_valid && out_result[DATA_W-1:HALF_W] == '0));

   assert_dest_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && legal) |=> (out_dest == $past(insn[4:0])));

   assert_hint_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && legal && insn[9:5] == insn[20:16]) |=> out_ror_hint);

   assert_outcome_onehot_R10: assert property (@(posedge clk) disable iff (rst)
      $onehot0({out_valid, out_undef, out_nomatch}) &&
      (out_ack == (out_valid || out_undef || out_nomatch)));

   assert_gated_zero_R10: assert property (@(posedge clk) disable iff (rst)
      (out_ack && !out_valid) |-> (out_result == '0 && out_dest == '0 && !out_ror_hint));

endmodule

bind pair_extract_unit pxu_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/pair_extract_unit_tb.sv
`timescale 1ns/1ps
module pair_extract_unit_tb;

   typedef struct packed {
      logic        sf;
      logic        n;
      logic        b21;
      logic [7:0]  pat;
      logic [4:0]  rm;
      logic [5:0]  imm;
      logic [4:0]  rn;
      logic [4:0]  rd;
      logic [63:0] a;
      logic [63:0] b;
      logic [3:0]  exp;   // {valid, undef, nomatch, hint}
   } vec_t;

   localparam int NV = 13;
   localparam logic [7:0] OK = 8'h27;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b1, 1'b0, OK,    5'd3,  6'd0,  5'd1,  5'd2,  64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 4'b1000},
      '{1'b1, 1'b1, 1'b0, OK,    5'd3,  6'd63, 5'd1,  5'd7,  64'h8000_0000_0000_0001, 64'hC000_0000_0000_0003, 4'b1000},
      '{1'b1, 1'b1, 1'b0, OK,    5'd4,  6'd17, 5'd4,  5'd11, 64'hDEAD_BEEF_CAFE_F00D, 64'hDEAD_BEEF_CAFE_F00D, 4'b1001},
      '{1'b0, 1'b0, 1'b0, OK,    5'd7,  6'd5,  5'd8,  5'd3,  64'hFFFF_FFFF_1234_5678, 64'hAAAA_AAAA_9ABC_DEF0, 4'b1000},
      '{1'b0, 1'b0, 1'b0, OK,    5'd7,  6'd31, 5'd8,  5'd4,  64'h5555_5555_8765_4321, 64'h0F0F_0F0F_F0F0_F0F0, 4'b1000},
      '{1'b0, 1'b0, 1'b0, OK,    5'd9,  6'd0,  5'd9,  5'd5,  64'hFFFF_FFFF_0000_0001, 64'h1111_1111_2222_2222, 4'b1001},
      '{1'b0, 1'b0, 1'b0, OK,    5'd9,  6'd32, 5'd1,  5'd6,  64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 4'b0100},
      '{1'b1, 1'b0, 1'b0, OK,    5'd2,  6'd4,  5'd2,  5'd8,  64'hAAAA_5555_AAAA_5555, 64'h3333_CCCC_3333_CCCC, 4'b0100},
      '{1'b0, 1'b1, 1'b0, OK,    5'd5,  6'd3,  5'd6,  5'd9,  64'h7777_7777_7777_7777, 64'h8888_8888_8888_8888, 4'b0100},
      '{1'b1, 1'b1, 1'b0, 8'h26, 5'd3,  6'd8,  5'd1,  5'd10, 64'h0000_FFFF_0000_FFFF, 64'hFFFF_0000_FFFF_0000, 4'b0010},
      '{1'b1, 1'b1, 1'b1, OK,    5'd3,  6'd8,  5'd1,  5'd12, 64'h0102_0304_0506_0708, 64'h090A_0B0C_0D0E_0F10, 4'b0010},
      '{1'b1, 1'b1, 1'b0, OK,    5'd30, 6'd32, 5'd31, 5'd13, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_0000_0000, 4'b1000},
      '{1'b1, 1'b1, 1'b0, OK,    5'd31, 6'd1,  5'd31, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 4'b1001}
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [31:0] insn;
   logic [63:0] opa, opb;
   logic        out_ack, out_valid, out_undef, out_nomatch, out_ror_hint;
   logic [4:0]  out_dest;
   logic [63:0] out_result;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   pair_extract_unit u_dut (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .insn         (insn),
      .opa          (opa),
      .opb          (opb),
      .out_ack      (out_ack),
      .out_valid    (out_valid),
      .out_undef    (out_undef),
      .out_nomatch  (out_nomatch),
      .out_ror_hint (out_ror_hint),
      .out_dest     (out_dest),
      .out_result   (out_result)
   );

   function automatic logic [63:0] ref_extract(logic sf, logic [5:0] imm,
                                               logic [63:0] a, logic [63:0] b);
      logic [127:0] w;
      logic [63:0]  nw;
      if (sf) begin
         w = {a, b} >> imm;
         return w[63:0];
      end
      nw = {a[31:0], b[31:0]} >> imm[4:0];
      return {32'h0, nw[31:0]};
   endfunction

   function automatic logic [31:0] build(vec_t v);
      return {v.sf, v.pat, v.n, v.b21, v.rm, v.imm, v.rn, v.rd};
   endfunction

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] last_res;
      logic [4:0]  last_dest;
      rst      = 1'b1;
      in_valid = 1'b0;
      insn     = '0;
      opa      = '0;
      opb      = '0;
      repeat (3) @(negedge clk);
      // R9: state after reset
      chk("R9", "ack after reset",    64'(out_ack),    64'd0);
      chk("R9", "valid after reset",  64'(out_valid),  64'd0);
      chk("R9", "result after reset", out_result,      64'd0);
      chk("R9", "dest after reset",   64'(out_dest),   64'd0);
      rst = 1'b0;
      @(negedge clk);

      // Vector table, issued back to back
      last_res  = '0;
      last_dest = '0;
      for (int i = 0; i < NV; i++) begin
         vec_t        v;
         logic [63:0] exp_res;
         logic [4:0]  exp_dest;
         string       rres;
         v        = VECS[i];
         insn     = build(v);
         opa      = v.a;
         opb      = v.b;
         in_valid = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         exp_res  = v.exp[3] ? ref_extract(v.sf, v.imm, v.a, v.b) : 64'd0;
         exp_dest = v.exp[3] ? v.rd : 5'd0;
         rres     = v.sf ? "R4" : "R5";
         chk("R8", $sformatf("vec%0d ack", i), 64'(out_ack), 64'd1);
         chk("R1", $sformatf("vec%0d nomatch", i), 64'(out_nomatch), 64'(v.exp[1]));
         chk((v.sf != v.n) ? "R2" : "R3", $sformatf("vec%0d undef", i),
             64'(out_undef), 64'(v.exp[2]));
         chk("R7", $sformatf("vec%0d hint", i), 64'(out_ror_hint), 64'(v.exp[0]));
         chk(v.exp[3] ? "R6" : "R10", $sformatf("vec%0d dest", i), 64'(out_dest), 64'(exp_dest));
         chk(v.exp[3] ? rres : "R10", $sformatf("vec%0d result", i), out_result, exp_res);
         chk("R10", $sformatf("vec%0d valid", i), 64'(out_valid), 64'(v.exp[3]));
         last_res  = exp_res;
         last_dest = exp_dest;
      end

      // R8: idle cycle with changed inputs leaves outputs held
      insn = build(VECS[0]);
      opa  = 64'hFFFF_FFFF_FFFF_FFFF;
      opb  = 64'h1234_1234_1234_1234;
      @(negedge clk);
      chk("R8", "idle ack",         64'(out_ack),   64'd0);
      chk("R8", "idle valid",       64'(out_valid), 64'd0);
      chk("R8", "idle result held", out_result,     last_res);
      chk("R8", "idle dest held",   64'(out_dest),  64'(last_dest));

      // R9: reset overrides a strobe in the same cycle
      in_valid = 1'b1;
      rst      = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      rst      = 1'b0;
      chk("R9", "reset beats strobe ack", 64'(out_ack),  64'd0);
      chk("R9", "reset beats strobe res", out_result,    64'd0);

      // R4: widest shift with all-ones high operand
      insn     = build(VECS[1]);
      opa      = 64'hFFFF_FFFF_FFFF_FFFF;
      opb      = 64'h0;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R4", "shift 63 result", out_result, 64'hFFFF_FFFF_FFFF_FFFE);

      // R9: reset after a result clears it
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R9", "reset clears result", out_result, 64'd0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule